// File: doc/BRIEF.md
# Masked Constrained Flag Enumerator

This block walks through every legal value of a 27-bit vector of test-feature flags and presents one value per request. A downstream stimulus engine uses it to build permission-checker scenarios. The engine reads `flags` while `valid` is high. It pulses `advance` to ask for the next value. Once the value space is used up, the block raises `done`.

A runtime mask removes flags that the platform under test cannot exercise. Masked flags stay zero in every value produced. Two feature-support inputs add the protection-key group and the supervisor-execution-protection flag to the mask when those features are absent.

Some flag combinations make no sense. The block steps past these by itself, one candidate per clock, and holds `valid` low until it reaches a legal value or the end of the space.

Flag positions, in bit order:
- Bits 0..6: leaf-entry flags, in the order present, writable, user, accessed, dirty, no-execute, reserved-51.
- Bits 7..15: directory-entry flags, in the order present, writable, user, accessed, dirty, large-page (12), no-execute, reserved-51, reserved-13 (15).
- Bits 16..18: key flags, in the order access-disable (16), write-disable (17), key-tag (18).
- Bits 19..22: access type, in the order user access (19), write (20), fetch (21), repeated access (22).
- Bits 23..26: control enables, in the order no-execute enable, write-protect, supervisor-execution protection (25), key enable (26).

Top module: `flagenum_top`

## Requirements
- R1: After reset, `flags` is 0, `valid` is 1 and `done` is 0. The all-zero value is the first one offered.
- R2: When `advance` is high while `valid` is high, the next candidate is ((flags | M) + 1) & ~M. M is the effective mask. The values offered therefore rise strictly, and `flags` holds steady while no advance arrives.
- R3: No value offered has any bit set that is set in the effective mask.
- R4: No value offered has both fetch (bit 21) and write (bit 20) set.
- R5: No value offered has both user access (bit 19) and supervisor-execution protection (bit 25) set.
- R6: No value offered has key access-disable (bit 16) or key write-disable (bit 17) set while key enable (bit 26) is clear.
- R7: No value offered has reserved-13 (bit 15) set while large-page (bit 12) is clear.
- R8: The effective mask is `maskIn` combined with two feature groups. When `keyFeatOk` is 0, bits 16, 17, 18 and 26 are added. When `supExecFeatOk` is 0, bit 25 is added.
- R9: Each illegal candidate costs one clock, and `valid` is low during that clock. A single illegal candidate gives exactly one cycle with `valid` low before the next legal value appears.
- R10: When the candidate reaches 2^27 or more, `done` goes high and `valid` goes low. Both stay that way until reset, and further advances have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| maskIn | input | 27 | Flags to exclude; hold stable outside reset |
| keyFeatOk | input | 1 | Protection-key feature available |
| supExecFeatOk | input | 1 | Supervisor-execution protection available |
| advance | input | 1 | Request the next legal value |
| flags | output | 27 | Current flag combination |
| valid | output | 1 | `flags` holds a legal value |
| done | output | 1 | Enumeration finished |

## Verification
The bench runs the enumeration to the end under several masks. Each mask leaves a small set of flags free that isolates one legality rule: fetch with write, user access with supervisor-execution protection, the key rules, and reserved-13 without large-page. It checks every value and the total count against hand-derived figures, so a skipped legal value or a leaked illegal value both show up.

Other runs cover different parts of the block:
- With the seven leaf bits free and no rule involved, 128 values must appear in counting order, which isolates the increment-with-mask step.
- With the feature inputs low, the effective mask must differ from the runtime mask.
- With only the key-enable bit free, the final carry must come out of the top bit.
- A directed run measures the one-cycle gap that a single illegal candidate causes, and the persistence of `done`.

// File: rtl/flagenum_pkg.sv
package flagenum_pkg;
  localparam int FLAG_COUNT = 27;

  localparam int B_DIR_LARGE   = 12;
  localparam int B_DIR_RSV13   = 15;
  localparam int B_KEY_ADIS    = 16;
  localparam int B_KEY_WDIS    = 17;
  localparam int B_KEY_TAG     = 18;
  localparam int B_ACC_USER    = 19;
  localparam int B_ACC_WRITE   = 20;
  localparam int B_ACC_FETCH   = 21;
  localparam int B_CTL_SUPEXEC = 25;
  localparam int B_CTL_KEYEN   = 26;

  typedef struct packed {
    logic step;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DONE   = 2'd2
  } enumState_t;

  function automatic logic isKeyBit(input int idx);
    return (idx == B_KEY_ADIS) || (idx == B_KEY_WDIS) ||
           (idx == B_KEY_TAG)  || (idx == B_CTL_KEYEN);
  endfunction

  function automatic logic isLegal(input logic [FLAG_COUNT-1:0] v);
    logic badAccess, badUser, badKey, badLarge;
    badAccess = v[B_ACC_FETCH] & v[B_ACC_WRITE];
    badUser   = v[B_ACC_USER] & v[B_CTL_SUPEXEC];
    badKey    = ~v[B_CTL_KEYEN] & (v[B_KEY_ADIS] | v[B_KEY_WDIS]);
    badLarge  = ~v[B_DIR_LARGE] & v[B_DIR_RSV13];
    return ~(badAccess | badUser | badKey | badLarge);
  endfunction
endpackage

// File: rtl/flagenum_datapath.sv
module flagenum_datapath
  import flagenum_pkg::*;
#(
  parameter int NUM_FLAGS = FLAG_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_FLAGS-1:0] maskIn,
  input  logic                 keyFeatOk,
  input  logic                 supExecFeatOk,
  output logic [NUM_FLAGS-1:0] curFlags,
  output logic                 nxtWrap,
  output logic                 nxtLegal
);
  localparam int SUM_W = NUM_FLAGS + 1;

  logic [NUM_FLAGS-1:0] forcedMask;
  logic [NUM_FLAGS-1:0] effMask;
  logic [SUM_W-1:0]     sum;
  logic [NUM_FLAGS-1:0] nxtFlags;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_force
    localparam logic KEY_BIT = isKeyBit(i);
    localparam logic SEP_BIT = (i == B_CTL_SUPEXEC);
    assign forcedMask[i] = (KEY_BIT & ~keyFeatOk) | (SEP_BIT & ~supExecFeatOk);
  end

  assign effMask  = maskIn | forcedMask;
  assign sum      = {1'b0, curFlags | effMask} + SUM_W'(1);
  assign nxtFlags = sum[NUM_FLAGS-1:0] & ~effMask;
  assign nxtWrap  = sum[NUM_FLAGS];
  assign nxtLegal = isLegal(nxtFlags[FLAG_COUNT-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      curFlags <= '0;
    end else if (strobe.step) begin
      curFlags <= nxtFlags;
    end
  end
endmodule

// File: rtl/flagenum_control.sv
module flagenum_control
  import flagenum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  input  logic        nxtWrap,
  input  logic        nxtLegal,
  output ctrlStrobe_t strobe,
  output logic        valid,
  output logic        done
);
  enumState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_READY, ST_SEARCH: begin
        if (state == ST_SEARCH || advance) begin
          if (nxtWrap) begin
            nextState = ST_DONE;
          end else begin
            strobe.step = 1'b1;
            nextState   = nxtLegal ? ST_READY : ST_SEARCH;
          end
        end
      end
      default: nextState = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_READY;
    else     state <= nextState;
  end

  assign valid = (state == ST_READY);
  assign done  = (state == ST_DONE);
endmodule

// File: rtl/flagenum_top.sv
module flagenum_top
  import flagenum_pkg::*;
#(
  parameter int NUM_FLAGS = FLAG_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] maskIn,
  input  logic                 keyFeatOk,
  input  logic                 supExecFeatOk,
  input  logic                 advance,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 valid,
  output logic                 done
);
  ctrlStrobe_t strobe;
  logic        nxtWrap;
  logic        nxtLegal;

  flagenum_datapath #(.NUM_FLAGS(NUM_FLAGS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .maskIn(maskIn),
    .keyFeatOk(keyFeatOk), .supExecFeatOk(supExecFeatOk),
    .curFlags(flags), .nxtWrap(nxtWrap), .nxtLegal(nxtLegal)
  );

  flagenum_control u_ctl (
    .clk(clk), .rst(rst), .advance(advance), .nxtWrap(nxtWrap),
    .nxtLegal(nxtLegal), .strobe(strobe), .valid(valid), .done(done)
  );
endmodule

// File: rtl/flagenum_checker.sv
module flagenum_checker
  import flagenum_pkg::*;
#(
  parameter int NUM_FLAGS = FLAG_COUNT
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FLAGS-1:0] maskIn,
  input logic                 keyFeatOk,
  input logic                 supExecFeatOk,
  input logic                 advance,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 valid,
  input logic                 done
);
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((flags & maskIn) == '0)); // R3
  AST_FETCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    valid |-> !(flags[B_ACC_FETCH] && flags[B_ACC_WRITE])); // R4
  AST_USER_SUPEXEC: assert property (@(posedge clk) disable iff (rst)
    valid |-> !(flags[B_ACC_USER] && flags[B_CTL_SUPEXEC])); // R5
  AST_KEY_RULE: assert property (@(posedge clk) disable iff (rst)
    (valid && !flags[B_CTL_KEYEN]) |-> !(flags[B_KEY_ADIS] || flags[B_KEY_WDIS])); // R6
  AST_RSV13_RULE: assert property (@(posedge clk) disable iff (rst)
    (valid && flags[B_DIR_RSV13]) |-> flags[B_DIR_LARGE]); // R7
  AST_KEY_FORCED: assert property (@(posedge clk) disable iff (rst)
    (valid && !keyFeatOk) |-> !(flags[B_KEY_ADIS] || flags[B_KEY_WDIS] ||
                                flags[B_KEY_TAG] || flags[B_CTL_KEYEN])); // R8
  AST_SEP_FORCED: assert property (@(posedge clk) disable iff (rst)
    (valid && !supExecFeatOk) |-> !flags[B_CTL_SUPEXEC]); // R8
  AST_GROWS: assert property (@(posedge clk) disable iff (rst)
    (valid && advance) |=> (done || (flags > $past(flags)))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !advance) |=> (valid && $stable(flags))); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !valid)); // R10
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(valid && done)); // R10
endmodule

bind flagenum_top flagenum_checker #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk(clk), .rst(rst), .maskIn(maskIn), .keyFeatOk(keyFeatOk),
  .supExecFeatOk(supExecFeatOk), .advance(advance), .flags(flags),
  .valid(valid), .done(done)
);

// File: tb/flagenum_top_test.sv
module flagenum_top_test;
  localparam int N = 27;
  localparam int NCASES = 10;

  typedef struct packed {
    logic [N-1:0] free;
    logic         keyOk;
    logic         sepOk;
    logic [15:0]  count;
  } caseVec_t;

  localparam caseVec_t CASES [NCASES] = '{
    '{free: 27'h0300000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd3},   // fetch+write
    '{free: 27'h2080000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd3},   // user+supexec
    '{free: 27'h2080000, keyOk: 1'b1, sepOk: 1'b0, count: 16'd2},   // supexec forced
    '{free: 27'h4030000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd5},   // key rule
    '{free: 27'h4030000, keyOk: 1'b0, sepOk: 1'b1, count: 16'd1},   // key forced
    '{free: 27'h0009000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd3},   // rsv13 rule
    '{free: 27'h000007F, keyOk: 1'b1, sepOk: 1'b1, count: 16'd128}, // plain counting
    '{free: 27'h2380000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd9},   // two rules
    '{free: 27'h4000000, keyOk: 1'b1, sepOk: 1'b1, count: 16'd2},   // top-bit wrap
    '{free: 27'h0080001, keyOk: 1'b1, sepOk: 1'b1, count: 16'd4}    // no rule touched
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] maskIn = '0;
  logic         keyFeatOk = 1'b1;
  logic         supExecFeatOk = 1'b1;
  logic         advance = 1'b0;
  logic [N-1:0] flags;
  logic         valid;
  logic         done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  flagenum_top uut (
    .clk(clk), .rst(rst), .maskIn(maskIn), .keyFeatOk(keyFeatOk),
    .supExecFeatOk(supExecFeatOk), .advance(advance), .flags(flags),
    .valid(valid), .done(done)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string caseTag(input int c);
    case (c)
      0, 7:    return "R4";
      1:       return "R5";
      2, 4:    return "R8";
      3:       return "R6";
      5:       return "R7";
      6, 9:    return "R2";
      default: return "R10";
    endcase
  endfunction

  function automatic logic legalRef(input logic [N-1:0] v);
    if (v[21] && v[20]) return 1'b0;
    if (v[19] && v[25]) return 1'b0;
    if (!v[26] && (v[16] || v[17])) return 1'b0;
    if (!v[12] && v[15]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [N:0] modelNext(input logic [N-1:0] cur,
                                           input logic [N-1:0] m);
    logic [N:0] v;
    v = {1'b0, cur};
    for (int k = 0; k < 100000; k++) begin
      v = ({1'b0, v[N-1:0] | m} + 1) & {1'b1, ~m};
      if (v[N]) return v;
      if (legalRef(v[N-1:0])) return v;
    end
    return v;
  endfunction

  task automatic doReset();
    rst = 1'b1;
    advance = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseAdvance();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic waitSettle();
    for (int k = 0; k < 64 && !valid && !done; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] eff;
    logic [N-1:0] cur;
    logic [N:0]   expNext;
    int           seen;
    int           maskBad;

    @(negedge clk);
    for (int c = 0; c < NCASES; c++) begin
      maskIn        = ~CASES[c].free;
      keyFeatOk     = CASES[c].keyOk;
      supExecFeatOk = CASES[c].sepOk;
      eff = maskIn;
      if (!keyFeatOk) eff = eff | (27'h1 << 16) | (27'h1 << 17) | (27'h1 << 18) | (27'h1 << 26);
      if (!supExecFeatOk) eff = eff | (27'h1 << 25);
      doReset();
      // R1: reset state
      check(flags == '0 && valid && !done, "R1", {valid, done, 3'b0, flags}, 32'h8000_0000);
      cur = '0;
      seen = 1;
      maskBad = 0;
      while (1) begin
        pulseAdvance();
        waitSettle();
        expNext = modelNext(cur, eff);
        if (expNext[N]) begin
          check(done && !valid, caseTag(c), {30'b0, valid, done}, 32'h1);
          break;
        end
        check(valid && flags == expNext[N-1:0], caseTag(c), {4'b0, valid, flags},
              {5'b1, expNext[N-1:0]});
        if ((flags & eff) != '0) maskBad++;
        cur = expNext[N-1:0];
        seen++;
        if (seen > 200) break;
      end
      check(seen == CASES[c].count, caseTag(c), seen, CASES[c].count);
      check(maskBad == 0, "R3", maskBad, 0);
    end

    // R9: one illegal candidate between two legal ones
    maskIn = ~27'h0009000;
    keyFeatOk = 1'b1;
    supExecFeatOk = 1'b1;
    doReset();
    pulseAdvance();
    check(valid && flags == 27'h0001000, "R9", {4'b0, valid, flags}, 32'h0800_1000);
    pulseAdvance();
    check(!valid && !done, "R9", {30'b0, valid, done}, 32'h0);
    @(negedge clk);
    check(valid && flags == 27'h0009000, "R9", {4'b0, valid, flags}, 32'h0800_9000);

    // R2: flags hold without advance
    repeat (3) @(negedge clk);
    check(valid && flags == 27'h0009000, "R2", {4'b0, valid, flags}, 32'h0800_9000);

    // R10: done persists and ignores advance
    pulseAdvance();
    waitSettle();
    check(done && !valid, "R10", {30'b0, valid, done}, 32'h1);
    pulseAdvance();
    pulseAdvance();
    @(negedge clk);
    check(done && !valid, "R10", {30'b0, valid, done}, 32'h1);

    // R1: reset clears done
    doReset();
    check(flags == '0 && valid && !done, "R1", {valid, done, 3'b0, flags}, 32'h8000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule